// File: doc/BRIEF.md
# Piecewise Nonlinear Error Gain

This block sits between the error sampler and the loop compensator of a digitally controlled power converter. Each signed error sample is sorted into one of five bands by four programmable signed thresholds. The band picks a gain code, and the block scales the sample by that code divided by four, so code 4 passes the sample through unchanged. The gain near zero error is kept small so that the loop holds its limit-cycle margin. Larger codes in the outer bands make the loop respond faster to big transients. The two upper thresholds and the two lower thresholds are programmed independently, so positive and negative excursions can get different boosts.

Thresholds and gain codes are held in nine registers. A one-cycle write port loads them, and a new value applies from the next sample on. Results appear one clock after the sample, together with a delayed copy of the valid flag. A result that does not fit the output width clamps to the nearest end of the signed range.

Top module: `nonlinear_err_gain`

## Requirements
- R1: While rst_ni is low and after its release, valid_o and data_o are 0, all four thresholds are 0 and all five gain codes are 4 (unity).
- R2: A sample strictly above threshold 0 uses gain code 0. A sample equal to threshold 0 does not.
- R3: A sample strictly above threshold 1 that is not above threshold 0 uses gain code 1. A sample equal to threshold 1 uses gain code 2.
- R4: A sample between threshold 2 and threshold 1, both ends included, uses gain code 2.
- R5: A sample strictly below threshold 2 that is not below threshold 3 uses gain code 3. A sample strictly below threshold 3 uses gain code 4. The bands may be asymmetric, for example +10, +4, -4, -12.
- R6: The result equals floor(error × gain / 4), an arithmetic right shift by two of the signed product.
- R7: A result above the largest or below the smallest OUT_W-bit signed value is clamped to that limit and does not wrap.
- R8: valid_o equals valid_i of the previous cycle. data_o changes only in the cycle after a cycle with valid_i high, and otherwise holds its value.
- R9: When cfg_we_i is high, cfg_addr_i 0..3 writes threshold 0..3 from cfg_data_i, and cfg_addr_i 4..8 writes gain code 0..4 from cfg_data_i[GAIN_W-1:0]. A sample taken in the same cycle as the write still uses the old value.
- R10: A write to cfg_addr_i 9..15 changes no threshold and no gain code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration register index |
| cfg_data_i | input | ERR_W | Threshold value or gain code |
| valid_i | input | 1 | Error sample is valid |
| err_i | input | ERR_W | Signed error sample |
| valid_o | output | 1 | Result is valid |
| data_o | output | OUT_W | Scaled and clamped signed result |

## Verification
Each scaled result and its valid flag appear exactly one clock after the edge that takes the sample. The bench drives the sample on a falling edge and reads the result on the next falling edge. A configuration write applies from the edge after the write, so the bench tests a write and a sample issued in the same cycle, and then repeats the sample one cycle later to see the new gain. The tests for ignored writes and for holding the output read data_o in the cycle after the idle or ignored stimulus and before any new sample is given.

// File: rtl/nlg_pkg.sv
package nlg_pkg;
  localparam int N_LIM     = 4;
  localparam int N_GAIN    = N_LIM + 1;
  localparam int ADDR_W    = 4;
  localparam int LIM_BASE  = 0;
  localparam int GAIN_BASE = N_LIM;
  localparam int NUM_CFG   = N_LIM + N_GAIN;
  localparam int SEL_W     = $clog2(N_GAIN);
endpackage

// File: rtl/nlg_cfg_regs.sv
module nlg_cfg_regs
  import nlg_pkg::*;
#(
  parameter int ERR_W  = 12,
  parameter int GAIN_W = 4,
  parameter int SHIFT  = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [ERR_W-1:0]                  data_i,
  output logic [N_LIM-1:0][ERR_W-1:0]       lim_o,
  output logic [N_GAIN-1:0][GAIN_W-1:0]     gain_o
);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1 << SHIFT);

  logic [N_LIM-1:0][ERR_W-1:0]   lim_q;
  logic [N_GAIN-1:0][GAIN_W-1:0] gain_q;

  for (genvar k = 0; k < N_LIM; k++) begin : g_lim
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      lim_q[k] <= '0;
      else if (we_i && addr_i == ADDR_W'(LIM_BASE + k)) lim_q[k] <= data_i;
    end
  end

  for (genvar k = 0; k < N_GAIN; k++) begin : g_gain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       gain_q[k] <= UNITY;
      else if (we_i && addr_i == ADDR_W'(GAIN_BASE + k)) gain_q[k] <= data_i[GAIN_W-1:0];
    end
  end

  assign lim_o  = lim_q;
  assign gain_o = gain_q;

  // R10: writes outside the map leave every register untouched
  a_r10_ignore_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i >= ADDR_W'(NUM_CFG)) |=> ($stable(lim_q) && $stable(gain_q)));
endmodule

// File: rtl/nlg_region_sel.sv
module nlg_region_sel
  import nlg_pkg::*;
#(
  parameter int ERR_W = 12
) (
  input  logic signed [ERR_W-1:0]      err_i,
  input  logic [N_LIM-1:0][ERR_W-1:0]  lim_i,
  output logic [SEL_W-1:0]             sel_o
);
  logic above0, above1, below2, below3;

  // upper thresholds: strict greater; lower: strict less -> ties fall inward
  assign above0 = err_i > $signed(lim_i[0]);
  assign above1 = err_i > $signed(lim_i[1]);
  assign below2 = err_i < $signed(lim_i[2]);
  assign below3 = err_i < $signed(lim_i[3]);

  always_comb begin
    if (above0)      sel_o = SEL_W'(0);
    else if (above1) sel_o = SEL_W'(1);
    else if (below3) sel_o = SEL_W'(4);
    else if (below2) sel_o = SEL_W'(3);
    else             sel_o = SEL_W'(2);
  end
endmodule

// File: rtl/nlg_scale.sv
module nlg_scale #(
  parameter int ERR_W  = 12,
  parameter int GAIN_W = 4,
  parameter int OUT_W  = 12,
  parameter int SHIFT  = 2
) (
  input  logic signed [ERR_W-1:0] err_i,
  input  logic [GAIN_W-1:0]       gain_i,
  output logic [OUT_W-1:0]        res_o
);
  localparam int PW    = ERR_W + GAIN_W + 1;
  localparam int O_MAX = (1 << (OUT_W - 1)) - 1;
  localparam int O_MIN = -(1 << (OUT_W - 1));

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shifted;
  int                   sh_i;

  assign prod    = PW'(err_i) * $signed({1'b0, gain_i});
  assign shifted = prod >>> SHIFT;
  assign sh_i    = int'(shifted);

  always_comb begin
    if (sh_i > O_MAX)      res_o = OUT_W'(O_MAX);
    else if (sh_i < O_MIN) res_o = OUT_W'(O_MIN);
    else                   res_o = OUT_W'(sh_i);
  end
endmodule

// File: rtl/nonlinear_err_gain.sv
module nonlinear_err_gain
  import nlg_pkg::*;
#(
  parameter int ERR_W  = 12,
  parameter int GAIN_W = 4,
  parameter int OUT_W  = 12,
  parameter int SHIFT  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_addr_i,
  input  logic [ERR_W-1:0]  cfg_data_i,
  input  logic              valid_i,
  input  logic [ERR_W-1:0]  err_i,
  output logic              valid_o,
  output logic [OUT_W-1:0]  data_o
);
  logic [N_LIM-1:0][ERR_W-1:0]   lim;
  logic [N_GAIN-1:0][GAIN_W-1:0] gain;
  logic [SEL_W-1:0]              sel;
  logic [GAIN_W-1:0]             sel_gain;
  logic [OUT_W-1:0]              res;
  logic signed [ERR_W-1:0]       err_s;

  assign err_s = $signed(err_i);

  nlg_cfg_regs #(.ERR_W(ERR_W), .GAIN_W(GAIN_W), .SHIFT(SHIFT)) i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .data_i (cfg_data_i),
    .lim_o  (lim),
    .gain_o (gain)
  );

  nlg_region_sel #(.ERR_W(ERR_W)) i_sel (
    .err_i (err_s),
    .lim_i (lim),
    .sel_o (sel)
  );

  assign sel_gain = gain[sel];

  nlg_scale #(.ERR_W(ERR_W), .GAIN_W(GAIN_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) i_scale (
    .err_i  (err_s),
    .gain_i (sel_gain),
    .res_o  (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= res;
    end
  end

  a_r8_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));

  a_r2_top_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_s > $signed(lim[0])) |-> sel == SEL_W'(0));

  a_r5_bottom_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_s < $signed(lim[3]) && err_s <= $signed(lim[1])) |-> sel == SEL_W'(4));

  a_r7_no_wrap_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && err_s > 0 && sel_gain != '0) |=> !data_o[OUT_W-1]);

  a_r7_no_wrap_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && err_s < 0 && sel_gain != '0) |=> data_o[OUT_W-1]);
endmodule

// File: tb/test_nonlinear_err_gain.sv
`timescale 1ns/1ps
module test_nonlinear_err_gain;
  localparam int ERR_W = 12;
  localparam int OUT_W = 12;
  localparam int NV    = 16;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we = 1'b0;
  logic [3:0]       cfg_addr = '0;
  logic [ERR_W-1:0] cfg_data = '0;
  logic             valid_i = 1'b0;
  logic [ERR_W-1:0] err = '0;
  logic             valid_o;
  logic [OUT_W-1:0] data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nonlinear_err_gain i_nonlinear_err_gain (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_data_i(cfg_data), .valid_i(valid_i), .err_i(err),
    .valid_o(valid_o), .data_o(data_o)
  );

  // {tag, error, expected}; limits +10,+4,-4,-12; gains 12,6,4,8,15
  localparam logic [26:0] VEC [NV] = '{
    {3'd0, 12'(11),    12'(33)},
    {3'd0, 12'(100),   12'(300)},
    {3'd1, 12'(10),    12'(15)},
    {3'd1, 12'(5),     12'(7)},
    {3'd1, 12'(7),     12'(10)},
    {3'd2, 12'(4),     12'(4)},
    {3'd2, 12'(0),     12'(0)},
    {3'd2, 12'(3),     12'(3)},
    {3'd2, 12'(-4),    12'(-4)},
    {3'd2, 12'(-1),    12'(-1)},
    {3'd3, 12'(-5),    12'(-10)},
    {3'd3, 12'(-11),   12'(-22)},
    {3'd3, 12'(-12),   12'(-24)},
    {3'd4, 12'(-13),   12'(-49)},
    {3'd5, 12'(2047),  12'(2047)},
    {3'd5, 12'(-2048), 12'(-2048)}
  };

  function automatic string tag_of(input logic [2:0] t);
    case (t)
      3'd0:    return "R2";
      3'd1:    return "R3";
      3'd2:    return "R4";
      3'd3:    return "R5";
      3'd4:    return "R5 R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int val);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_data = ERR_W'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive a sample, read result one clock later
  task automatic smp(input int e, output int res, output int vld);
    valid_i = 1'b1; err = ERR_W'(e);
    @(negedge clk);
    valid_i = 1'b0;
    res = int'($signed(data_o));
    vld = int'(valid_o);
  endtask

  initial begin
    int r, v;
    repeat (3) @(negedge clk);
    chk("R1", int'(valid_o), 0);
    chk("R1", int'(data_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", int'(valid_o), 0);
    // defaults: all gains unity
    smp(-7, r, v);  chk("R1", r, -7);
    smp(9, r, v);   chk("R1", r, 9);

    wr(0, 10); wr(1, 4); wr(2, -4); wr(3, -12);
    wr(4, 12); wr(5, 6); wr(6, 4); wr(7, 8); wr(8, 15);

    for (int i = 0; i < NV; i++) begin
      smp(int'($signed(VEC[i][23:12])), r, v);
      chk(tag_of(VEC[i][26:24]), r, int'($signed(VEC[i][11:0])));
      chk("R8", v, 1);
    end

    // R8: idle cycle keeps data, drops valid
    @(negedge clk);
    chk("R8", int'(valid_o), 0);
    chk("R8", int'($signed(data_o)), -2048);

    // R9: write and sample in the same cycle -> old gain; next sample -> new
    cfg_we = 1'b1; cfg_addr = 4'd6; cfg_data = ERR_W'(8);
    valid_i = 1'b1; err = ERR_W'(3);
    @(negedge clk);
    cfg_we = 1'b0; valid_i = 1'b0;
    chk("R9", int'($signed(data_o)), 3);
    smp(3, r, v);  chk("R9", r, 6);
    wr(6, 4);
    smp(3, r, v);  chk("R9", r, 3);

    // R10: writes outside the map have no effect
    wr(9, 1); wr(12, -100); wr(15, 0);
    @(negedge clk);
    chk("R10", int'($signed(data_o)), 3);
    smp(3, r, v);   chk("R10", r, 3);
    smp(11, r, v);  chk("R10", r, 33);
    smp(-13, r, v); chk("R10", r, -49);
    smp(-4, r, v);  chk("R10", r, -4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule